// File: doc/BRIEF.md
# Frame-Clock Sync Guard for Serial Audio

This block sits between a serial-audio deserializer and the audio processing core. It runs on a fast core clock from a PLL and checks that the incoming frame (word-select) clock stays in step with that clock. It counts core cycles between successive frame-clock rising edges. The link counts as in sync only when each count lies within ±TOL of an expected ratio `n_i` and the PLL reports lock. When detection is enabled and sync is missing, the samples sent to processing are forced to zero at once and a freeze request goes out to the processing tasks.

The block also routes the left and right input samples to the two processing channels. Each channel has its own select, and a new select takes effect at a frame boundary. An optional delay of one core cycle can be applied to the bit clock for masters with marginal timing. Software sees a live sync status and a sticky loss flag that a one-cycle pulse clears.

Top module: `i2s_sync_guard`

## Requirements
- R1: With the PLL locked and a steady frame period of P core cycles, `sync_ok_o` ends up high if and only if n_i-4 <= P <= n_i+4 (TOL=4).
- R2: When `pll_lock_i` is low in any cycle, `sync_ok_o` is low in the next cycle, whatever the measured period.
- R3: After reset, or after a loss, `sync_ok_o` rises only after two consecutive in-window periods. A single out-of-window period drops it.
- R4: When the frame clock stops, sync is declared lost once the running count passes n_i+4. The count saturates and never wraps.
- R5: With `detect_en_i`=1 and sync missing or lock low, `freeze_o` is high in the same cycle and `ch1_o`/`ch2_o` are zero from the next cycle. `sample_vld_o` still follows `sample_vld_i` one cycle later.
- R6: With `detect_en_i`=0, `freeze_o` is low and the samples pass unmuted, even when out of sync.
- R7: With `sck_delay_en_i`=1, `sck_o` equals `sck_i` delayed by exactly one core cycle. With 0, `sck_o` equals `sck_i`.
- R8: A channel select of 0 routes the left input to that channel and 1 routes the right input. A new select takes effect only at the next frame-clock rising edge.
- R9: After reset the selects are channel 1 = 0 and channel 2 = 1 (identity mapping), whatever the select ports carry, until the first frame edge.
- R10: `desync_sticky_o` sets when `sync_ok_o` falls and clears one cycle after a `clr_sticky_i` pulse. If a set and a clear fall in the same cycle, the set wins.
- R11: `ch1_o`, `ch2_o` and `sample_vld_o` are registered: they show the mapped inputs one cycle after they are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock from the PLL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lrck_i | input | 1 | Frame clock, asynchronous to the core clock |
| sck_i | input | 1 | Bit clock as sampled in the core domain |
| sck_delay_en_i | input | 1 | 1 selects the bit clock delayed by one core cycle |
| sck_o | output | 1 | Bit clock for the deserializer |
| pll_lock_i | input | 1 | PLL lock indication |
| detect_en_i | input | 1 | Enables muting and freezing on loss of sync |
| n_i | input | CNT_W | Expected core cycles per frame |
| ch1_sel_i | input | 1 | Channel 1 source: 0 left, 1 right |
| ch2_sel_i | input | 1 | Channel 2 source: 0 left, 1 right |
| left_i | input | DW | Left input sample |
| right_i | input | DW | Right input sample |
| sample_vld_i | input | 1 | Input sample strobe |
| ch1_o | output | DW | Sample sent to processing channel 1 |
| ch2_o | output | DW | Sample sent to processing channel 2 |
| sample_vld_o | output | 1 | Output sample strobe |
| freeze_o | output | 1 | Freeze request to the processing tasks |
| sync_ok_o | output | 1 | Current sync state |
| desync_sticky_o | output | 1 | Sticky flag set on loss of sync |
| clr_sticky_i | input | 1 | One-cycle clear of the sticky flag |

## Verification
Two events can land in the same cycle: the loss of sync that sets the sticky flag, and a clear pulse from software. The bench drops PLL lock while sync is held, on the same clock as a `clr_sticky_i` pulse. It expects the flag to read 1 afterwards, because the set wins (R10). In that same cycle a sample strobe also arrives. The bench requires `sample_vld_o` to appear on time while the data is already zero, which shows that muting and strobe timing coincide without one disturbing the other (R5).

// File: rtl/i2s_sync_pkg.sv
package i2s_sync_pkg;
  typedef enum logic [1:0] {
    TRK_LOST = 2'd0,
    TRK_HALF = 2'd1,
    TRK_OK   = 2'd2
  } trk_state_e;

  typedef struct packed {
    logic rise;
    logic good;
    logic bad;
  } meas_ev_t;
endpackage

// File: rtl/sync_period_meter.sv
module sync_period_meter
  import i2s_sync_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int TOL         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lrck_i,
  input  logic [CNT_W-1:0] n_i,
  output meas_ev_t         ev_o
);
  localparam int W1 = CNT_W + 1;
  localparam logic [W1-1:0] TOL_X = W1'(TOL);

  logic [SYNC_STAGES:0] sh_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 armed_q;
  logic                 rise;
  logic [W1-1:0]        cnt_x, n_x;
  logic                 in_win, timeout;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], lrck_i};
  end

  assign rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

  // saturating period counter: a stalled frame clock reads as too long
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_q | rise;
      if (rise)            cnt_q <= CNT_W'(1);
      else if (cnt_q != '1) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_x   = {1'b0, cnt_q};
  assign n_x     = {1'b0, n_i};
  assign in_win  = (cnt_x + TOL_X >= n_x) && (cnt_x <= n_x + TOL_X);
  assign timeout = (cnt_x == n_x + TOL_X + W1'(1));

  assign ev_o.rise = rise;
  assign ev_o.good = rise & armed_q & in_win;
  assign ev_o.bad  = armed_q & (rise ? ~in_win : timeout);
endmodule

// File: rtl/sync_tracker.sv
module sync_tracker
  import i2s_sync_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  meas_ev_t ev_i,
  input  logic     pll_lock_i,
  input  logic     clr_i,
  output logic     sync_ok_o,
  output logic     sticky_o
);
  trk_state_e state_q, state_d;
  logic bad, good, loss;

  assign bad  = ev_i.bad | ~pll_lock_i;
  assign good = ev_i.good & pll_lock_i;
  assign loss = (state_q == TRK_OK) & bad;

  always_comb begin
    state_d = state_q;
    if (bad) state_d = TRK_LOST;
    else if (good) begin
      unique case (state_q)
        TRK_LOST: state_d = TRK_HALF;
        default:  state_d = TRK_OK;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= TRK_LOST;
      sticky_o <= 1'b0;
    end else begin
      state_q <= state_d;
      if (loss)       sticky_o <= 1'b1; // set beats clear
      else if (clr_i) sticky_o <= 1'b0;
    end
  end

  assign sync_ok_o = (state_q == TRK_OK);
endmodule

// File: rtl/sample_router.sv
module sample_router #(
  parameter int         DW      = 24,
  parameter logic [1:0] SEL_RST = 2'b10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_tick_i,
  input  logic [1:0]    sel_i,
  input  logic [DW-1:0] left_i,
  input  logic [DW-1:0] right_i,
  input  logic          vld_i,
  input  logic          mute_i,
  output logic [DW-1:0] ch_o [2],
  output logic          vld_o
);
  for (genvar g = 0; g < 2; g++) begin : g_ch
    logic          sel_q;
    logic [DW-1:0] dat_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sel_q <= SEL_RST[g];
        dat_q <= '0;
      end else begin
        if (frame_tick_i) sel_q <= sel_i[g];
        dat_q <= mute_i ? '0 : (sel_q ? right_i : left_i);
      end
    end

    assign ch_o[g] = dat_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_o <= 1'b0;
    else         vld_o <= vld_i;
  end
endmodule

// File: rtl/i2s_sync_guard.sv
module i2s_sync_guard
  import i2s_sync_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int TOL   = 4,
  parameter int DW    = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lrck_i,
  input  logic             sck_i,
  input  logic             sck_delay_en_i,
  output logic             sck_o,
  input  logic             pll_lock_i,
  input  logic             detect_en_i,
  input  logic [CNT_W-1:0] n_i,
  input  logic             ch1_sel_i,
  input  logic             ch2_sel_i,
  input  logic [DW-1:0]    left_i,
  input  logic [DW-1:0]    right_i,
  input  logic             sample_vld_i,
  output logic [DW-1:0]    ch1_o,
  output logic [DW-1:0]    ch2_o,
  output logic             sample_vld_o,
  output logic             freeze_o,
  output logic             sync_ok_o,
  output logic             desync_sticky_o,
  input  logic             clr_sticky_i
);
  meas_ev_t      ev;
  logic          sck_q;
  logic          mute;
  logic [DW-1:0] ch [2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_i;
  end
  assign sck_o = sck_delay_en_i ? sck_q : sck_i;

  sync_period_meter #(.CNT_W(CNT_W), .TOL(TOL), .SYNC_STAGES(2)) i_meter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lrck_i (lrck_i),
    .n_i    (n_i),
    .ev_o   (ev)
  );

  sync_tracker i_tracker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_i       (ev),
    .pll_lock_i (pll_lock_i),
    .clr_i      (clr_sticky_i),
    .sync_ok_o  (sync_ok_o),
    .sticky_o   (desync_sticky_o)
  );

  // lock loss mutes in the same cycle, before the tracker registers it
  assign mute     = detect_en_i & (~sync_ok_o | ~pll_lock_i);
  assign freeze_o = mute;

  sample_router #(.DW(DW), .SEL_RST(2'b10)) i_router (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_tick_i (ev.rise),
    .sel_i        ({ch2_sel_i, ch1_sel_i}),
    .left_i       (left_i),
    .right_i      (right_i),
    .vld_i        (sample_vld_i),
    .mute_i       (mute),
    .ch_o         (ch),
    .vld_o        (sample_vld_o)
  );

  assign ch1_o = ch[0];
  assign ch2_o = ch[1];
endmodule

// File: rtl/i2s_sync_guard_chk.sv
module i2s_sync_guard_chk #(
  parameter int DW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pll_lock_i,
  input logic          detect_en_i,
  input logic          freeze_o,
  input logic          sync_ok_o,
  input logic          desync_sticky_o,
  input logic          clr_sticky_i,
  input logic [DW-1:0] ch1_o,
  input logic [DW-1:0] ch2_o,
  input logic          sample_vld_i,
  input logic          sample_vld_o
);
  a_r2_unlock_drops_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pll_lock_i |=> !sync_ok_o);

  a_r3_rise_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_ok_o) |-> $past(pll_lock_i));

  a_r5_freeze_on_unlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (detect_en_i && !pll_lock_i) |-> freeze_o);

  a_r5_mute_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_o |=> (ch1_o == '0 && ch2_o == '0));

  a_r5_vld_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_vld_i |=> sample_vld_o);

  a_r5_vld_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_vld_i |=> !sample_vld_o);

  a_r6_no_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !detect_en_i |-> !freeze_o);

  a_r10_sticky_on_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_ok_o) |-> desync_sticky_o);

  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_sticky_i && !sync_ok_o) |=> !desync_sticky_o);
endmodule

bind i2s_sync_guard i2s_sync_guard_chk #(.DW(DW)) i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .pll_lock_i      (pll_lock_i),
  .detect_en_i     (detect_en_i),
  .freeze_o        (freeze_o),
  .sync_ok_o       (sync_ok_o),
  .desync_sticky_o (desync_sticky_o),
  .clr_sticky_i    (clr_sticky_i),
  .ch1_o           (ch1_o),
  .ch2_o           (ch2_o),
  .sample_vld_i    (sample_vld_i),
  .sample_vld_o    (sample_vld_o)
);

// File: tb/test_i2s_sync_guard.sv
`timescale 1ns/1ps
module test_i2s_sync_guard;
  localparam int CNT_W = 12;
  localparam int DW    = 24;
  localparam logic [DW-1:0] LV = 24'h123456;
  localparam logic [DW-1:0] RV = 24'hABCDEF;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic lrck_i = 1'b0, sck_i = 1'b0, sck_delay_en_i = 1'b0;
  logic pll_lock_i = 1'b1, detect_en_i = 1'b0;
  logic [CNT_W-1:0] n_i = 12'd16;
  logic ch1_sel_i = 1'b1, ch2_sel_i = 1'b0;
  logic [DW-1:0] left_i = LV, right_i = RV;
  logic sample_vld_i = 1'b0, clr_sticky_i = 1'b0;
  logic sck_o, sample_vld_o, freeze_o, sync_ok_o, desync_sticky_o;
  logic [DW-1:0] ch1_o, ch2_o;

  int n_tests = 0, n_fail = 0;
  int lr_per = 16, ph = 15, rise_cnt = 0;
  bit lr_run = 1'b0;

  always #5 clk = ~clk;

  i2s_sync_guard #(.CNT_W(CNT_W), .TOL(4), .DW(DW)) i_i2s_sync_guard (
    .clk_i(clk), .rst_ni(rst_ni), .lrck_i(lrck_i), .sck_i(sck_i),
    .sck_delay_en_i(sck_delay_en_i), .sck_o(sck_o), .pll_lock_i(pll_lock_i),
    .detect_en_i(detect_en_i), .n_i(n_i), .ch1_sel_i(ch1_sel_i),
    .ch2_sel_i(ch2_sel_i), .left_i(left_i), .right_i(right_i),
    .sample_vld_i(sample_vld_i), .ch1_o(ch1_o), .ch2_o(ch2_o),
    .sample_vld_o(sample_vld_o), .freeze_o(freeze_o), .sync_ok_o(sync_ok_o),
    .desync_sticky_o(desync_sticky_o), .clr_sticky_i(clr_sticky_i)
  );

  // frame clock: high for the first half of each period
  always @(negedge clk) begin
    if (lr_run) begin
      if (ph + 1 >= lr_per) begin
        ph = 0;
        rise_cnt++;
      end else ph = ph + 1;
      lrck_i <= (ph < lr_per / 2);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic after_rise(input int k);
    while (rise_cnt < k) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    lr_run = 1'b0;
    lrck_i = 1'b0;
    ph = lr_per - 1;
    rise_cnt = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] pat;
    int base;
    pat = 8'b1011_0010;
    repeat (2) @(negedge clk);
    chk("RST sync_ok", 32'(sync_ok_o), 0);
    chk("RST sticky", 32'(desync_sticky_o), 0);
    chk("RST ch1", 32'(ch1_o), 0);
    chk("RST vld", 32'(sample_vld_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    // selects on ports are swapped, reset mapping must still be identity
    chk("R9 ch1 left", 32'(ch1_o), 32'(LV));
    chk("R9 ch2 right", 32'(ch2_o), 32'(RV));
    chk("R6 no freeze", 32'(freeze_o), 0);
    left_i = 24'h0F0F0F;
    @(negedge clk);
    chk("R11 ch1 follows", 32'(ch1_o), 32'h0F0F0F);
    left_i = LV;

    // R8: swap takes effect at the frame edge
    lr_run = 1'b1;
    after_rise(1);
    chk("R8 ch1 right", 32'(ch1_o), 32'(RV));
    chk("R8 ch2 left", 32'(ch2_o), 32'(LV));
    ch1_sel_i = 1'b0; ch2_sel_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 held until edge", 32'(ch1_o), 32'(RV));
    after_rise(2);
    chk("R8 ch1 left", 32'(ch1_o), 32'(LV));
    chk("R8 ch2 left", 32'(ch2_o), 32'(LV));
    ch2_sel_i = 1'b1;

    // R7: bit-clock delay
    for (int d = 0; d < 2; d++) begin
      sck_delay_en_i = d[0];
      for (int b = 0; b < 8; b++) begin
        @(negedge clk);
        sck_i = pat[b];
        #1;
        chk(d ? "R7 delayed" : "R7 direct", 32'(sck_o),
            32'(d ? (b == 0 ? pat[7] : pat[b-1]) : pat[b]));
      end
    end
    sck_delay_en_i = 1'b0;

    // R1: period sweep around n=16
    for (int p = 8; p <= 24; p++) begin
      lr_per = p;
      do_reset();
      lr_run = 1'b1;
      after_rise(5);
      chk($sformatf("R1 period %0d", p), 32'(sync_ok_o), 32'(p >= 12 && p <= 20));
    end

    // R3: hysteresis and single bad period
    lr_per = 16;
    do_reset();
    lr_run = 1'b1;
    after_rise(2);
    chk("R3 one good not enough", 32'(sync_ok_o), 0);
    after_rise(3);
    chk("R3 two good", 32'(sync_ok_o), 1);
    lr_per = 26;
    after_rise(4);
    chk("R3 bad drops", 32'(sync_ok_o), 0);
    chk("R10 sticky set", 32'(desync_sticky_o), 1);
    lr_per = 16;
    after_rise(5);
    chk("R3 regain one", 32'(sync_ok_o), 0);
    after_rise(6);
    chk("R3 regain two", 32'(sync_ok_o), 1);
    clr_sticky_i = 1'b1;
    @(negedge clk);
    clr_sticky_i = 1'b0;
    @(negedge clk);
    chk("R10 cleared", 32'(desync_sticky_o), 0);

    // R5/R2/R10: unlock with clear and strobe in the same cycle
    detect_en_i = 1'b1;
    @(negedge clk);
    chk("R5 synced pass", 32'(ch1_o), 32'(LV));
    chk("R5 no freeze synced", 32'(freeze_o), 0);
    pll_lock_i = 1'b0; clr_sticky_i = 1'b1; sample_vld_i = 1'b1;
    #1;
    chk("R5 freeze same cycle", 32'(freeze_o), 1);
    @(negedge clk);
    chk("R5 ch1 muted", 32'(ch1_o), 0);
    chk("R5 ch2 muted", 32'(ch2_o), 0);
    chk("R5 vld kept", 32'(sample_vld_o), 1);
    chk("R2 unlock", 32'(sync_ok_o), 0);
    chk("R10 set wins", 32'(desync_sticky_o), 1);
    clr_sticky_i = 1'b0; sample_vld_i = 1'b0;
    @(negedge clk);
    chk("R11 vld low", 32'(sample_vld_o), 0);
    clr_sticky_i = 1'b1;
    @(negedge clk);
    clr_sticky_i = 1'b0;
    chk("R10 clear pulse", 32'(desync_sticky_o), 0);

    // R6: detection disabled passes data out of sync
    detect_en_i = 1'b0;
    #1;
    chk("R6 freeze off", 32'(freeze_o), 0);
    @(negedge clk);
    chk("R6 unmuted", 32'(ch1_o), 32'(LV));
    pll_lock_i = 1'b1; detect_en_i = 1'b1;
    #1;
    chk("R5 freeze while unsynced", 32'(freeze_o), 1);
    base = rise_cnt;
    after_rise(base + 3);
    chk("R2 relock", 32'(sync_ok_o), 1);
    chk("R5 released", 32'(ch1_o), 32'(LV));

    // R4: stalled frame clock
    lr_run = 1'b0;
    repeat (40) @(negedge clk);
    chk("R4 timeout", 32'(sync_ok_o), 0);
    chk("R4 muted", 32'(ch1_o), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule